// File: doc/BRIEF.md
# Locked Translation Entry Table with Gated Programming Port

This block holds a small set of pinned address translations, eight by default. Software fills them one at a time through four register slots addressed by `reg_sel`. The index slot picks an entry. The virtual-page slot, the attribute slot and the physical-page slot then fill that entry. An entry only joins lookups once its physical-page slot has been written.

Every register access carries two mode bits, secure and privileged. Only a secure privileged access is honoured. Any other access raises `undef` and changes nothing. A separate lock input refuses secure writes in the same way but lets reads through.

A combinational lookup port compares a virtual page number and address-space ID against the valid entries. It returns the hit, the physical page and the attributes. It also flags a permission fault when an instruction fetch hits an execute-never entry.

Top module: `tlb_lock_port`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits, and the index slot reads 0.
- R2: An access that is not both secure (`sec`=1) and privileged (`priv`=1) pulses `undef` in the cycle after the strobe. It gives no `rd_valid`, and no entry or index changes.
- R3: While `wr_lock` is 1, a secure privileged write pulses `undef` and stores nothing. Reads in the same mode still complete normally.
- R4: Writing the virtual-page slot (`reg_sel`=1) or the attribute slot (`reg_sel`=2) marks the selected entry invalid. Writing the physical-page slot (`reg_sel`=3) marks it valid.
- R5: The attribute word places the fields as follows: bit 25 sub-page, bits 10:7 domain, bit 6 execute-never, bits 5:3 TEX, bit 2 C, bit 1 B, bit 0 shareable. Bits 31:26 and 24:11 read back as zero whatever was written.
- R6: An index write (`reg_sel`=0) of N or more selects entry N-1.
- R7: A granted read returns the selected slot of the indexed entry on `rd_data`, with a one-cycle `rd_valid` pulse, in the cycle after the strobe. The virtual-page word has the page number in bits 31:12, the global flag in bit 9 and the ASID in bits 7:0. The physical-page word has the page number in bits 31:12. The index word has the index in its low bits.
- R8: A lookup hits a valid entry whose page number matches when the entry is global, or when its ASID equals `lk_asid`. The port then shows that entry's physical page and attributes.
- R9: `lk_fault` is 1 when `lk_ifetch` is 1 and the hit entry has execute-never set. A data lookup (`lk_ifetch`=0) never faults.
- R10: A granted attribute write with bit 25 set, to an entry whose stored global flag is 0, pulses `attr_err`. It leaves the entry's attributes and valid flag unchanged.
- R11: When several valid entries match, the lowest-numbered entry supplies the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | 0 index, 1 virtual page, 2 attributes, 3 physical page |
| reg_wdata | input | 32 | Write data |
| sec | input | 1 | Access is from the secure world |
| priv | input | 1 | Access is privileged |
| wr_lock | input | 1 | Refuse secure writes |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data |
| undef | output | 1 | Access refused pulse |
| attr_err | output | 1 | Rejected sub-page attribute write pulse |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Current address-space ID |
| lk_ifetch | input | 1 | Lookup is an instruction fetch |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | VPN_W | Physical page of the hit entry |
| lk_domain | output | 4 | Domain of the hit entry |
| lk_xn | output | 1 | Execute-never of the hit entry |
| lk_tex | output | 3 | TEX field of the hit entry |
| lk_c | output | 1 | C bit of the hit entry |
| lk_b | output | 1 | B bit of the hit entry |
| lk_s | output | 1 | Shareable bit of the hit entry |
| lk_subpage | output | 1 | Sub-page flag of the hit entry |
| lk_fault | output | 1 | Permission fault on fetch of execute-never page |

## Verification
The bench targets the partly programmed entry. A design that set the valid flag on the virtual-page or attribute write would hit on stale translations. The refused accesses come from user mode, non-secure mode and locked writes. Each is followed by a readback, so a design that let any of them store data shows a changed word. The bench also writes an out-of-range index, a sub-page attribute to a non-global entry, and overlapping entries with the same page. A design that wrapped the index, stored the bad attribute or picked the highest match returns the wrong entry. Random programming and lookups, mixing global and ASID-tagged entries, check the hit, the physical page and the fault against a bench model.

// File: rtl/tlb_lock_port.sv
module tlb_lock_port #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              sec,
  input  logic              priv,
  input  logic              wr_lock,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              undef,
  output logic              attr_err,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_ifetch,
  output logic              lk_hit,
  output logic [VPN_W-1:0]  lk_ppn,
  output logic [3:0]        lk_domain,
  output logic              lk_xn,
  output logic [2:0]        lk_tex,
  output logic              lk_c,
  output logic              lk_b,
  output logic              lk_s,
  output logic              lk_subpage,
  output logic              lk_fault
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int PG    = 32 - VPN_W;
  localparam logic [1:0] S_IDX = 2'd0, S_VA = 2'd1, S_ATTR = 2'd2, S_PA = 2'd3;

  logic [VPN_W-1:0]  e_vpn  [N];
  logic [ASID_W-1:0] e_asid [N];
  logic [VPN_W-1:0]  e_ppn  [N];
  logic [11:0]       e_attr [N];
  logic [N-1:0]      e_g;
  logic [N-1:0]      e_valid;
  logic [IDX_W-1:0]  idx;

  wire mode_ok = sec && priv;
  wire granted = reg_en && mode_ok && !(reg_wr && wr_lock);
  wire do_wr   = granted && reg_wr;
  wire do_rd   = granted && !reg_wr;
  wire bad_sp  = do_wr && reg_sel == S_ATTR && reg_wdata[25] && !e_g[idx];

  logic [IDX_W-1:0] idx_next;
  always_comb begin
    if (reg_wdata >= 32'(N)) idx_next = IDX_W'(N - 1);
    else                     idx_next = reg_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx     <= '0;
      e_valid <= '0;
    end else if (do_wr) begin
      case (reg_sel)
        S_IDX:  idx <= idx_next;
        S_VA:   e_valid[idx] <= 1'b0;
        S_ATTR: if (!bad_sp) e_valid[idx] <= 1'b0;
        default: e_valid[idx] <= 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      case (reg_sel)
        S_VA: begin
          e_vpn[idx]  <= reg_wdata[31:PG];
          e_g[idx]    <= reg_wdata[9];
          e_asid[idx] <= reg_wdata[ASID_W-1:0];
        end
        S_ATTR: if (!bad_sp) e_attr[idx] <= {reg_wdata[25], reg_wdata[10:0]};
        S_PA:   e_ppn[idx] <= reg_wdata[31:PG];
        default: ;
      endcase
    end
  end

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    case (reg_sel)
      S_IDX: rd_word[IDX_W-1:0] = idx;
      S_VA: begin
        rd_word[31:PG]        = e_vpn[idx];
        rd_word[9]            = e_g[idx];
        rd_word[ASID_W-1:0]   = e_asid[idx];
      end
      S_ATTR: begin
        rd_word[25]   = e_attr[idx][11];
        rd_word[10:0] = e_attr[idx][10:0];
      end
      default: rd_word[31:PG] = e_ppn[idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      undef    <= 1'b0;
      attr_err <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      undef    <= reg_en && !granted;
      attr_err <= bad_sp;
      if (do_rd) rd_data <= rd_word;
    end
  end

  logic [N-1:0] match;
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = e_valid[i] && e_vpn[i] == lk_vpn && (e_g[i] || e_asid[i] == lk_asid);
  end

  logic [IDX_W-1:0] sel_i;
  always_comb begin
    sel_i = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match[i]) sel_i = IDX_W'(i);
  end

  assign lk_hit     = |match;
  assign lk_ppn     = lk_hit ? e_ppn[sel_i] : '0;
  assign {lk_subpage, lk_domain, lk_xn, lk_tex, lk_c, lk_b, lk_s} = lk_hit ? e_attr[sel_i] : 12'd0;
  assign lk_fault   = lk_hit && lk_ifetch && lk_xn;

  AST_BLOCKED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !mode_ok) |=> ($stable(e_valid) && $stable(idx) && undef && !rd_valid)); // R2
  AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_wr && wr_lock) |=> ($stable(e_valid) && $stable(idx) && undef)); // R3
  AST_VA_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && reg_sel == S_VA) |=> !e_valid[$past(idx)]); // R4
  AST_PA_VALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && reg_sel == S_PA) |=> e_valid[$past(idx)]); // R4
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(reg_en && !reg_wr && mode_ok)); // R7
  AST_SP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    attr_err |-> ($stable(e_valid) && !undef)); // R10
  AST_FAULT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_ifetch && lk_hit)); // R9
endmodule

// File: tb/sim_tlb_lock_port.sv
`timescale 1ns/1ps
module sim_tlb_lock_port;
  logic clk = 0, rst_n = 0;
  logic reg_en = 0, reg_wr = 0, sec = 0, priv = 0, wr_lock = 0, lk_ifetch = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [19:0] lk_vpn = 0;
  logic [7:0] lk_asid = 0;
  logic rd_valid, undef, attr_err, lk_hit, lk_xn, lk_c, lk_b, lk_s, lk_subpage, lk_fault;
  logic [31:0] rd_data;
  logic [19:0] lk_ppn;
  logic [3:0] lk_domain;
  logic [2:0] lk_tex;

  always #4 clk = ~clk;

  tlb_lock_port u0 (.*);

  int total = 0, bad = 0;
  logic finished = 0;

  logic [19:0] m_vpn [8];
  logic [19:0] m_ppn [8];
  logic [7:0]  m_asid [8];
  logic [11:0] m_attr [8];
  logic [7:0]  m_g, m_valid;
  logic [2:0]  m_idx;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_word(input logic [1:0] s);
    logic [31:0] w = '0;
    case (s)
      0: w[2:0] = m_idx;
      1: begin w[31:12] = m_vpn[m_idx]; w[9] = m_g[m_idx]; w[7:0] = m_asid[m_idx]; end
      2: begin w[25] = m_attr[m_idx][11]; w[10:0] = m_attr[m_idx][10:0]; end
      default: w[31:12] = m_ppn[m_idx];
    endcase
    return w;
  endfunction

  task automatic acc(input logic wr, input logic [1:0] s, input logic [31:0] d,
                     input logic sc, input logic pv, input string req);
    logic ok, e_rv, e_ae;
    logic [31:0] e_rd;
    ok = sc && pv && !(wr && wr_lock);
    e_rv = ok && !wr;
    e_ae = 0;
    e_rd = m_word(s);
    @(negedge clk);
    reg_en = 1; reg_wr = wr; reg_sel = s; reg_wdata = d; sec = sc; priv = pv;
    @(negedge clk);
    reg_en = 0;
    if (ok && wr) begin
      case (s)
        0: m_idx = (d >= 8) ? 3'd7 : d[2:0];
        1: begin m_vpn[m_idx] = d[31:12]; m_g[m_idx] = d[9]; m_asid[m_idx] = d[7:0]; m_valid[m_idx] = 0; end
        2: if (d[25] && !m_g[m_idx]) e_ae = 1;
           else begin m_attr[m_idx] = {d[25], d[10:0]}; m_valid[m_idx] = 0; end
        default: begin m_ppn[m_idx] = d[31:12]; m_valid[m_idx] = 1; end
      endcase
    end
    chk(undef === !ok, req, 64'(undef), 64'(!ok));
    chk(rd_valid === e_rv, req, 64'(rd_valid), 64'(e_rv));
    chk(attr_err === e_ae, req, 64'(attr_err), 64'(e_ae));
    if (e_rv) chk(rd_data === e_rd, req, 64'(rd_data), 64'(e_rd));
  endtask

  task automatic lk(input logic [19:0] v, input logic [7:0] a, input logic f, input string req);
    logic eh; logic [31:0] er; int hi;
    eh = 0; hi = 0;
    for (int i = 7; i >= 0; i--)
      if (m_valid[i] && m_vpn[i] == v && (m_g[i] || m_asid[i] == a)) begin eh = 1; hi = i; end
    lk_vpn = v; lk_asid = a; lk_ifetch = f;
    #1;
    chk(lk_hit === eh, req, 64'(lk_hit), 64'(eh));
    if (eh) begin
      er = {m_ppn[hi], m_attr[hi]};
      chk({lk_ppn, lk_subpage, lk_domain, lk_xn, lk_tex, lk_c, lk_b, lk_s} === er, req,
          64'({lk_ppn, lk_subpage, lk_domain, lk_xn, lk_tex, lk_c, lk_b, lk_s}), 64'(er));
      chk(lk_fault === (f && m_attr[hi][6]), req, 64'(lk_fault), 64'(f && m_attr[hi][6]));
    end else chk(lk_fault === 0, req, 64'(lk_fault), 0);
  endtask

  task automatic prog(input int i, input logic [19:0] v, input logic g, input logic [7:0] a,
                      input logic [11:0] at, input logic [19:0] p, input string req);
    acc(1, 0, i, 1, 1, req);
    acc(1, 1, {v, 2'b0, g, 1'b0, a}, 1, 1, req);
    acc(1, 2, {6'b0, at[11], 14'h0, at[10:0]}, 1, 1, req);
    acc(1, 3, {p, 12'h0}, 1, 1, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1176));
    m_g = 0; m_valid = 0; m_idx = 0;
    for (int i = 0; i < 8; i++) begin m_vpn[i] = 0; m_ppn[i] = 0; m_asid[i] = 0; m_attr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    lk(20'h0, 8'h0, 0, "R1");
    acc(0, 0, 0, 1, 1, "R1");
    // R4: partial programming gives no hit
    acc(1, 0, 0, 1, 1, "R4");
    acc(1, 1, {20'h12345, 2'b0, 1'b1, 1'b0, 8'h00}, 1, 1, "R4");
    lk(20'h12345, 0, 0, "R4");
    acc(1, 2, 32'hFFFF_F8C5, 1, 1, "R4");
    acc(1, 2, 32'h0000_0245, 1, 1, "R4");
    lk(20'h12345, 0, 0, "R4");
    acc(1, 3, {20'hABCDE, 12'h0}, 1, 1, "R4");
    lk(20'h12345, 8'h77, 0, "R8");
    // R5 / R7: readback with zeroed reserved bits
    acc(1, 2, 32'hFFFF_FFC5, 1, 1, "R5");
    acc(0, 2, 0, 1, 1, "R5");
    acc(0, 1, 0, 1, 1, "R7");
    lk(20'h12345, 0, 0, "R4");
    acc(1, 3, {20'hABCDE, 12'h0}, 1, 1, "R4");
    acc(0, 3, 0, 1, 1, "R7");
    // R9: fetch faults on execute-never (bit 6 set above), data does not
    lk(20'h12345, 0, 1, "R9");
    lk(20'h12345, 0, 0, "R9");
    // R2: user and non-secure accesses refused
    acc(1, 3, 32'h11111000, 1, 0, "R2");
    acc(1, 0, 32'd5, 0, 1, "R2");
    acc(0, 3, 0, 0, 1, "R2");
    acc(0, 3, 0, 1, 1, "R2");
    acc(0, 0, 0, 1, 1, "R2");
    // R3: locked writes refused, reads still allowed
    wr_lock = 1;
    acc(1, 1, 32'hFFFFF2FF, 1, 1, "R3");
    acc(0, 1, 0, 1, 1, "R3");
    lk(20'h12345, 0, 0, "R3");
    wr_lock = 0;
    // R6: index clamp
    acc(1, 0, 32'd13, 1, 1, "R6");
    acc(0, 0, 0, 1, 1, "R6");
    acc(1, 0, 32'hFFFF_FFFF, 1, 1, "R6");
    acc(0, 0, 0, 1, 1, "R6");
    // R10: sub-page needs global
    prog(2, 20'h00777, 0, 8'h21, 12'h00F, 20'h00042, "R10");
    acc(1, 2, 32'h0200_0003, 1, 1, "R10");
    acc(0, 2, 0, 1, 1, "R10");
    lk(20'h00777, 8'h21, 0, "R10");
    prog(3, 20'h00888, 1, 8'h00, 12'h801, 20'h00043, "R10");
    acc(0, 2, 0, 1, 1, "R10");
    // R8: ASID tagging
    lk(20'h00777, 8'h22, 0, "R8");
    lk(20'h00777, 8'h21, 1, "R8");
    // R11: overlapping entries, lowest index wins
    prog(5, 20'h0BEEF, 1, 8'h00, 12'h010, 20'h00555, "R11");
    prog(6, 20'h0BEEF, 1, 8'h00, 12'h040, 20'h00666, "R11");
    lk(20'h0BEEF, 8'h09, 1, "R11");
    prog(4, 20'h0BEEF, 0, 8'h09, 12'h002, 20'h00444, "R11");
    lk(20'h0BEEF, 8'h09, 0, "R11");
    lk(20'h0BEEF, 8'h0A, 0, "R11");
    // Random programming and lookups
    for (int it = 0; it < 60; it++) begin
      logic g; logic [11:0] at;
      g = 1'($urandom);
      at = 12'($urandom);
      if (!g) at[11] = 0;
      prog($urandom % 10, 20'($urandom % 16), g, 8'($urandom % 4), at, 20'($urandom), "R8");
      for (int k = 0; k < 10; k++)
        lk(20'($urandom % 16), 8'($urandom % 4), 1'($urandom), "R8");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule